// File: doc/BRIEF.md
# Two-Step Product Code Encoder

This block turns one small information frame into a 7-by-7 bit product codeword. The first step works along the rows. Five 3-bit data symbols are treated as elements of GF(8) and extended with two parity symbols, which gives a Reed-Solomon (7,5,3) codeword. That codeword is laid out as a binary image: bit row `i` holds the coefficient of basis element α^i for every symbol, using the basis 1, α, α². A fourth row carries seven auxiliary information bits. The second step works down the columns. Each of the seven four-bit columns is extended with three Hamming (7,4) parity bits.

A frame enters in one valid/ready transfer and is then encoded over a fixed sequence of cycles. Row parity is accumulated one symbol per cycle. One cycle solves for the two parity symbols, and one cycle forms the column parity and loads the output array. The finished array is held on the output until the next frame completes. A single-cycle done strobe marks each new result.

Top module: `pc_product_encoder`

## Requirements
- R1: While `rst_n` is low, `in_ready` and `out_done` are 0 and `out_cw` is all zeros. `in_ready` goes high on the second rising clock edge after `rst_n` is released.
- R2: A frame is taken on a rising edge where both `in_valid` and `in_ready` are high. `in_ready` then stays low until the encode finishes.
- R3: `out_done` is high for exactly one cycle, starting on the 7th rising edge after the accepting edge.
- R4: Bit `out_cw[r*7+c]` is row `r`, column `c`. For rows 0..2 and columns 0..4 it equals `in_sym[3*c+r]`, which is bit `r` (the coefficient of α^r) of data symbol `c`.
- R5: Row 3 of `out_cw` equals `in_aux`, with column `c` taken from `in_aux[c]`.
- R6: Columns 5 and 6 of rows 0..2 hold the two parity symbols. GF(8) uses x³+x+1 with α=3'b010. The seven row symbols, read as polynomial coefficients c0..c6, evaluate to zero at 1 and at α. As a result, each of rows 0..2 has even parity.
- R7: For every column, with bits b0..b6 taken from rows 0..6: b4 = b0^b1^b3, b5 = b0^b2^b3 and b6 = b1^b2^b3.
- R8: `out_cw` changes only together with a done strobe. An `in_valid` raised while `in_ready` is low takes no frame and does not alter the next result.
- R9: `in_ready` is high during the done cycle, so a frame held waiting is taken on the following edge. This gives results 8 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Frame offered |
| in_ready | output | 1 | Encoder idle and able to take a frame |
| in_sym | input | 15 | Five 3-bit data symbols; symbol c at bits 3c+2..3c |
| in_aux | input | 7 | Auxiliary row bits, column c at bit c |
| out_done | output | 1 | One-cycle strobe: new codeword on `out_cw` |
| out_cw | output | 49 | Codeword array, row r column c at bit 7r+c |

## Verification
Some rules are checked on every cycle. The done strobe lasts one cycle. Ready drops after a transfer and is high in the done cycle. The output array holds between strobes. Whenever the strobe is high, every binary-image row has even parity and every column meets the three Hamming checks. Other behaviours can only be shown by the bench scenarios, which compare against a reference model on every clock. These are the exact placement of data and auxiliary bits, the true GF(8) parity symbols (the zero at α, not only the one at 1), the seven-cycle latency, a request ignored while busy, and a back-to-back transfer taken in the done cycle.

// File: rtl/pc_pkg.sv
package pc_pkg;
  localparam int GF_M   = 3;
  localparam int RS_N   = 7;
  localparam int RS_K   = 5;
  localparam int COL_N  = 7;
  localparam int COL_K  = 4;
  localparam int COL_P  = COL_N - COL_K;
  localparam int DATA_W = GF_M * RS_K;
  localparam int AUX_W  = RS_N;
  localparam int CW_W   = COL_N * RS_N;
  localparam int IDX_W  = $clog2(RS_K);

  // Information-row masks of the three column checks (bit r = row r)
  localparam logic [COL_P-1:0][COL_K-1:0] COL_MASK = {4'b1110, 4'b1101, 4'b1011};

  typedef logic [GF_M-1:0] gf_t;

  typedef enum logic [1:0] {ST_IDLE, ST_ACC, ST_PAR, ST_COL} enc_state_t;

  // Multiply by alpha modulo x^3 + x + 1
  function automatic gf_t gf_mul_alpha(gf_t a);
    return {a[1], a[0] ^ a[2], a[2]};
  endfunction

  function automatic gf_t gf_mul_apow(gf_t a, int n);
    gf_t t;
    t = a;
    for (int i = 0; i < n; i++) t = gf_mul_alpha(t);
    return t;
  endfunction
endpackage

// File: rtl/pc_ctrl.sv
module pc_ctrl
  import pc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_l,
  input  logic             in_valid,
  output logic             ready,
  output logic             accept,
  output logic             step,
  output logic             par_we,
  output logic             col_we,
  output logic [IDX_W-1:0] sym_idx
);
  enc_state_t       st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  assign ready   = (st_q == ST_IDLE) && rst_l;
  assign accept  = ready && in_valid;
  assign step    = (st_q == ST_ACC);
  assign par_we  = (st_q == ST_PAR);
  assign col_we  = (st_q == ST_COL);
  assign sym_idx = idx_q;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        st_d  = ST_ACC;
        idx_d = IDX_W'(RS_K - 1);
      end
      ST_ACC: begin
        if (idx_q == '0) st_d = ST_PAR;
        else             idx_d = idx_q - 1'b1;
      end
      ST_PAR:  st_d = ST_COL;
      ST_COL:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end
endmodule

// File: rtl/pc_rs_accum.sv
module pc_rs_accum
  import pc_pkg::*;
(
  input  logic clk,
  input  logic rst_l,
  input  logic clr,
  input  logic step,
  input  gf_t  sym,
  output gf_t  par_lo,
  output gf_t  par_hi
);
  // s0 = sum of symbols (value at 1), s1 = value at alpha by Horner, highest index first
  gf_t s0_q, s1_q, s0_d, s1_d;

  always_comb begin
    s0_d = s0_q;
    s1_d = s1_q;
    if (clr) begin
      s0_d = '0;
      s1_d = '0;
    end else if (step) begin
      s0_d = s0_q ^ sym;
      s1_d = gf_mul_alpha(s1_q) ^ sym;
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      s0_q <= '0;
      s1_q <= '0;
    end else begin
      s0_q <= s0_d;
      s1_q <= s1_d;
    end
  end

  // Parity at positions 5 and 6: p5 = a^6*s1 + a^5*s0, p6 = s0 + p5
  assign par_lo = gf_mul_apow(s1_q, 6) ^ gf_mul_apow(s0_q, 5);
  assign par_hi = s0_q ^ par_lo;
endmodule

// File: rtl/pc_col_encoder.sv
module pc_col_encoder
  import pc_pkg::*;
(
  input  logic [RS_N-1:0][COL_K-1:0] info,
  output logic [RS_N-1:0][COL_P-1:0] par
);
  for (genvar c = 0; c < RS_N; c++) begin : g_col
    for (genvar p = 0; p < COL_P; p++) begin : g_chk
      assign par[c][p] = ^(info[c] & COL_MASK[p]);
    end
  end
endmodule

// File: rtl/pc_product_encoder.sv
module pc_product_encoder
  import pc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_sym,
  input  logic [AUX_W-1:0]  in_aux,
  output logic              out_done,
  output logic [CW_W-1:0]   out_cw
);
  logic [1:0] rsync_q;
  logic       rst_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_l = rsync_q[1];

  logic             accept, step, par_we, col_we;
  logic [IDX_W-1:0] sym_idx;

  pc_ctrl u_ctrl (
    .clk     (clk),
    .rst_l   (rst_l),
    .in_valid(in_valid),
    .ready   (in_ready),
    .accept  (accept),
    .step    (step),
    .par_we  (par_we),
    .col_we  (col_we),
    .sym_idx (sym_idx)
  );

  logic [DATA_W-1:0] data_q;
  logic [AUX_W-1:0]  aux_q;
  gf_t               par_lo, par_hi;
  logic [1:0][GF_M-1:0] par_q;
  gf_t               cur_sym;

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      data_q <= '0;
      aux_q  <= '0;
    end else if (accept) begin
      data_q <= in_sym;
      aux_q  <= in_aux;
    end
  end

  assign cur_sym = data_q[sym_idx*GF_M +: GF_M];

  pc_rs_accum u_rs (
    .clk   (clk),
    .rst_l (rst_l),
    .clr   (accept),
    .step  (step),
    .sym   (cur_sym),
    .par_lo(par_lo),
    .par_hi(par_hi)
  );

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l)      par_q <= '0;
    else if (par_we) par_q <= {par_hi, par_lo};
  end

  // Information rows of the array, then column parity
  logic [COL_K-1:0][RS_N-1:0] grid;
  logic [RS_N-1:0][COL_K-1:0] col_info;
  logic [RS_N-1:0][COL_P-1:0] col_par;
  logic [CW_W-1:0]            cw_d;

  always_comb begin
    for (int r = 0; r < GF_M; r++) begin
      for (int c = 0; c < RS_N; c++) begin
        if (c < RS_K) grid[r][c] = data_q[c*GF_M + r];
        else          grid[r][c] = par_q[c-RS_K][r];
      end
    end
    grid[COL_K-1] = aux_q;
    for (int c = 0; c < RS_N; c++)
      for (int r = 0; r < COL_K; r++)
        col_info[c][r] = grid[r][c];
  end

  pc_col_encoder u_col (
    .info(col_info),
    .par (col_par)
  );

  always_comb begin
    cw_d = '0;
    for (int r = 0; r < COL_K; r++)
      cw_d[r*RS_N +: RS_N] = grid[r];
    for (int p = 0; p < COL_P; p++)
      for (int c = 0; c < RS_N; c++)
        cw_d[(COL_K+p)*RS_N + c] = col_par[c][p];
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      out_cw   <= '0;
      out_done <= 1'b0;
    end else begin
      out_done <= col_we;
      if (col_we) out_cw <= cw_d;
    end
  end
endmodule

// File: rtl/pc_product_encoder_chk.sv
module pc_product_encoder_chk
  import pc_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_done,
  input logic [CW_W-1:0] out_cw
);
  logic rows_even;
  logic cols_ok;
  logic [COL_N-1:0] b;

  always_comb begin
    rows_even = 1'b1;
    for (int r = 0; r < GF_M; r++)
      if (^out_cw[r*RS_N +: RS_N]) rows_even = 1'b0;
    cols_ok = 1'b1;
    b = '0;
    for (int c = 0; c < RS_N; c++) begin
      for (int r = 0; r < COL_N; r++) b[r] = out_cw[r*RS_N + c];
      if (b[0] ^ b[1] ^ b[3] ^ b[4]) cols_ok = 1'b0;
      if (b[0] ^ b[2] ^ b[3] ^ b[5]) cols_ok = 1'b0;
      if (b[1] ^ b[2] ^ b[3] ^ b[6]) cols_ok = 1'b0;
    end
  end

  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |=> !out_done); // R3
  AST_ROWS_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> rows_even); // R6
  AST_COLS_CHECKED: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> cols_ok); // R7
  AST_CW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_done |-> $stable(out_cw)); // R8
  AST_READY_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> in_ready); // R9
endmodule

bind pc_product_encoder pc_product_encoder_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_valid(in_valid),
  .in_ready(in_ready),
  .out_done(out_done),
  .out_cw  (out_cw)
);

// File: tb/pc_product_encoder_test.sv
module pc_product_encoder_test;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [14:0] in_sym;
  logic [6:0]  in_aux;
  logic        out_done;
  logic [48:0] out_cw;

  int checks = 0;
  int errors = 0;

  pc_product_encoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sym(in_sym), .in_aux(in_aux), .out_done(out_done), .out_cw(out_cw)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // ---------------- reference arithmetic ----------------
  function automatic logic [2:0] gmul(logic [2:0] a, logic [2:0] b);
    logic [2:0] r, t;
    r = 0; t = a;
    for (int i = 0; i < 3; i++) begin
      if (b[i]) r ^= t;
      t = {t[1], t[0] ^ t[2], t[2]};
    end
    return r;
  endfunction

  function automatic logic [2:0] peval(logic [6:0][2:0] c, logic [2:0] x);
    logic [2:0] acc, pw;
    acc = 0; pw = 3'b001;
    for (int j = 0; j < 7; j++) begin
      acc ^= gmul(c[j], pw);
      pw = gmul(pw, x);
    end
    return acc;
  endfunction

  function automatic logic [48:0] expect_cw(logic [14:0] sym, logic [6:0] aux);
    logic [6:0][2:0] c;
    logic [48:0] w;
    logic [6:0] col;
    for (int j = 0; j < 5; j++) c[j] = sym[3*j +: 3];
    c[5] = 0; c[6] = 0;
    for (int p5 = 0; p5 < 8; p5++)
      for (int p6 = 0; p6 < 8; p6++) begin
        logic [6:0][2:0] t;
        t = c; t[5] = 3'(p5); t[6] = 3'(p6);
        if (peval(t, 3'b001) == 0 && peval(t, 3'b010) == 0) begin
          c[5] = 3'(p5); c[6] = 3'(p6);
        end
      end
    w = 0;
    for (int r = 0; r < 3; r++)
      for (int j = 0; j < 7; j++) w[r*7 + j] = c[j][r];
    for (int j = 0; j < 7; j++) w[21 + j] = aux[j];
    for (int j = 0; j < 7; j++) begin
      for (int r = 0; r < 4; r++) col[r] = w[r*7 + j];
      w[28 + j] = col[0] ^ col[1] ^ col[3];
      w[35 + j] = col[0] ^ col[2] ^ col[3];
      w[42 + j] = col[1] ^ col[2] ^ col[3];
    end
    return w;
  endfunction

  // ---------------- cycle model ----------------
  int          sc = 0;
  int          cnt = 0;
  logic        m_done = 0;
  logic [48:0] m_cw = 0;
  logic [48:0] pend = 0;
  int          cyc = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      sc = 0; cnt = 0; m_done = 0; m_cw = 0;
    end else begin
      m_done = 0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin m_done = 1; m_cw = pend; end
      end else if (sc >= 2 && in_valid) begin
        cnt = 7;
        pend = expect_cw(in_sym, in_aux);
      end
      if (sc < 2) sc++;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (in_ready !== (sc >= 2 && cnt == 0)) begin
        errors++;
        $display("FAIL R2 in_ready cycle %0d: got %b exp %b", cyc, in_ready, (sc >= 2 && cnt == 0));
      end
      checks++;
      if (out_done !== m_done) begin
        errors++;
        $display("FAIL R3 out_done cycle %0d: got %b exp %b", cyc, out_done, m_done);
      end
      checks++;
      if (out_cw !== m_cw) begin
        errors++;
        $display("FAIL R8 out_cw cycle %0d: got %h exp %h", cyc, out_cw, m_cw);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h exp %h", tag, act, exp);
    end
  endtask

  task automatic send(logic [14:0] s, logic [6:0] a);
    in_valid = 1; in_sym = s; in_aux = a;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  int last_done = 0;

  task automatic wait_done(logic [14:0] s, logic [6:0] a);
    int t;
    logic [48:0] e;
    logic [6:0] col;
    t = 0;
    while (!out_done && t < 50) begin @(negedge clk); t++; end
    check(out_done, "R3 done seen", 64'(out_done), 64'd1);
    last_done = cyc;
    e = expect_cw(s, a);
    check(out_cw[20:0] == e[20:0] && out_cw[6:0] !== 'x, "R6 rows 0..2 image", 64'(out_cw[20:0]), 64'(e[20:0]));
    for (int r = 0; r < 3; r++)
      for (int j = 0; j < 5; j++)
        check(out_cw[r*7 + j] == s[3*j + r], "R4 systematic bit", 64'(out_cw[r*7 + j]), 64'(s[3*j + r]));
    check(out_cw[27:21] == a, "R5 aux row", 64'(out_cw[27:21]), 64'(a));
    for (int r = 0; r < 3; r++)
      check(^out_cw[r*7 +: 7] == 1'b0, "R6 row even parity", 64'(out_cw[r*7 +: 7]), 64'd0);
    for (int j = 0; j < 7; j++) begin
      for (int r = 0; r < 7; r++) col[r] = out_cw[r*7 + j];
      check(col[4] == (col[0]^col[1]^col[3]) && col[5] == (col[0]^col[2]^col[3]) &&
            col[6] == (col[1]^col[2]^col[3]), "R7 column checks", 64'(col), 64'(e[j]));
    end
    @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [14:0] sa, sb;
    logic [6:0]  aa, ab;
    int first;
    rst_n = 0; in_valid = 0; in_sym = 0; in_aux = 0;
    repeat (3) @(negedge clk);
    check(in_ready == 0 && out_done == 0 && out_cw == 0, "R1 reset state",
          64'({in_ready, out_done, out_cw != 0}), 64'd0);
    rst_n = 1;
    @(negedge clk);
    check(in_ready == 0, "R1 ready still low after one edge", 64'(in_ready), 64'd0);
    @(negedge clk);
    check(in_ready == 1, "R1 ready after second edge", 64'(in_ready), 64'd1);

    // R4 R5 R6 R7: fixed patterns
    send(15'h0000, 7'h00); wait_done(15'h0000, 7'h00);
    send(15'h7fff, 7'h7f); wait_done(15'h7fff, 7'h7f);
    for (int j = 0; j < 5; j++) begin
      send(15'(3'b001) << (3*j), 7'(1) << j);
      wait_done(15'(3'b001) << (3*j), 7'(1) << j);
    end
    send(15'h4a52, 7'h35); wait_done(15'h4a52, 7'h35);

    // R8: request while busy is ignored, result unchanged
    sa = 15'h1234; aa = 7'h2b; sb = 15'h6dcb; ab = 7'h54;
    send(sa, aa);
    in_valid = 1; in_sym = sb; in_aux = ab;
    repeat (3) @(negedge clk);
    in_valid = 0;
    wait_done(sa, aa);
    check(out_cw == expect_cw(sa, aa), "R8 busy request ignored", 64'(out_cw), 64'(expect_cw(sa, aa)));
    repeat (3) @(negedge clk);
    check(out_cw == expect_cw(sa, aa), "R8 output held", 64'(out_cw), 64'(expect_cw(sa, aa)));

    // R9: back-to-back transfer taken in done cycle
    send(sb, ab);
    in_valid = 1; in_sym = sa; in_aux = ab;
    while (!out_done) @(negedge clk);
    first = cyc;
    @(negedge clk);
    in_valid = 0;
    wait_done(sa, ab);
    check(last_done - first == 8, "R9 done spacing", 64'(last_done - first), 64'd8);

    // random frames
    for (int n = 0; n < 20; n++) begin
      sa = 15'($urandom); aa = 7'($urandom);
      send(sa, aa); wait_done(sa, aa);
    end

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule